// File: doc/BRIEF.md
# Three-Rail Power Sequencer Controller

This block enables three downstream power regulators in a fixed order and disables them in the reverse order. It has three active-high release flags. A single enable level controls the whole sequence. When enable goes high, the flags rise one at a time, lowest first. When enable goes low, they fall one at a time, highest first. There is no other start or stop control.

Each flag transition waits for its own delay, counted in cycles of the one master clock. There are six delay values: three for the rises and three for the falls, each set on a static input port. The rise delays and the fall delays are independent of each other. The enable input is asynchronous and passes through a two-flop synchroniser. If enable changes while a sequence is still running, the block reverses from the point it has reached. A two-bit status output reports which phase the block is in.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is low and after it is released with enable low, all three flags are 0 and status is 0 (idle-low).
- R2: The flags form a thermometer value: only 000, 001, 011 and 111 appear, and at most one flag changes per clock cycle.
- R3: After enable rises (counted from the first clock edge following the change), flag 1 rises at edge `up_dly_f1 + 4`. This covers 2 synchroniser cycles, 1 load cycle, and the counted delay plus 1.
- R4: Each later rise follows the previous flag change by its delay plus one cycle: flag 2 by `up_dly_f2 + 1` and flag 3 by `up_dly_f3 + 1`.
- R5: After enable falls, flag 3 falls at edge `dn_dly_f3 + 4`. Then flag 2 falls `dn_dly_f2 + 1` cycles later, and flag 1 falls `dn_dly_f1 + 1` cycles after that.
- R6: A delay value of zero makes the transition happen on the clock edge right after the previous step, so the spacing is one cycle.
- R7: If enable falls during a rise sequence, no further flag rises. The highest asserted flag falls `4 +` its own fall delay cycles after the enable change.
- R8: If enable rises during a fall sequence, no further flag falls. The lowest deasserted flag rises `4 +` its own rise delay cycles after the enable change.
- R9: The status encoding is 0 = idle-low, 1 = ramping up, 2 = all high, 3 = ramping down. Status shows 1 or 3 while a partial flag pattern is held during a sequence. It shows 2 once all flags are high and 0 once all are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock that times all delays |
| rst_n | input | 1 | Synchronous active-low reset |
| en_async | input | 1 | Asynchronous sequence enable level |
| up_dly_f1 | input | CNT_W | Delay before flag 1 rises |
| up_dly_f2 | input | CNT_W | Delay before flag 2 rises |
| up_dly_f3 | input | CNT_W | Delay before flag 3 rises |
| dn_dly_f1 | input | CNT_W | Delay before flag 1 falls |
| dn_dly_f2 | input | CNT_W | Delay before flag 2 falls |
| dn_dly_f3 | input | CNT_W | Delay before flag 3 falls |
| flags | output | 3 | Release flags; bit 0 is flag 1 |
| status | output | 2 | Phase: 0 idle-low, 1 up, 2 all-high, 3 down |

## Verification
Full rise and fall sequences are driven with random delay sets in the range 0 to 7. With random values, swapping two delays or using the wrong delay for a step shows up as a wrong spacing. A set of all-zero delays tests the one-cycle edge case, which separates an off-by-one in the counter from a correct reload. Two directed reversals, enable falling after the first rise and enable rising after the first fall, show whether the block resumes from the correct flag with the correct delay table. They also show whether it wrongly completes the interrupted sequence.

// File: rtl/seq_pkg.sv
// Package: shared types for the rail sequencer.
// Assumes three flags; the delay width is a parameter of the users.
package seq_pkg;
    localparam int NUM_FLAGS = 3;

    typedef enum logic [1:0] {
        ST_IDLE_LOW  = 2'd0,
        ST_RAMP_UP   = 2'd1,
        ST_ALL_HIGH  = 2'd2,
        ST_RAMP_DOWN = 2'd3
    } seq_status_e;
endpackage

// File: rtl/en_sync.sv
// Module: en_sync
// Brings an asynchronous level into the clock domain through a chain of
// flops. Assumes the input is a slow level, not a pulse.
module en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/step_timer.sv
// Module: step_timer
// Shared down-counter. Load has priority; otherwise it counts down to zero
// and holds there. Assumes the controller loads before each step.
module step_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             at_zero
);
    logic [CNT_W-1:0] cnt;

    // Load a new delay or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign at_zero = (cnt == '0);
endmodule

// File: rtl/seq_ctrl.sv
// Module: seq_ctrl
// Holds the flag level (number of asserted flags) and the armed step.
// On a change of the synchronised enable it arms a step in the new
// direction, picking the delay of the flag that moves next. When the timer
// reaches zero it takes the step and rearms if the sequence is unfinished.
// Assumes the delay inputs are static while a step is armed.
module seq_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_s,
    input  logic                  at_zero,
    input  logic [2:0][CNT_W-1:0] up_dly,
    input  logic [2:0][CNT_W-1:0] dn_dly,
    output logic                  load,
    output logic [CNT_W-1:0]      load_val,
    output logic [1:0]            lvl,
    output seq_pkg::seq_status_e  status
);
    import seq_pkg::*;

    logic       armed, arm_up;
    logic       want, reversing, start, fire, cont, use_up;
    logic [1:0] lvl_nx;

    // Decide whether to arm, fire or rearm in this cycle.
    always_comb begin
        want      = en_s ? (lvl != 2'd3) : (lvl != 2'd0);
        reversing = armed && (arm_up != en_s);
        start     = want && (!armed || reversing);
        fire      = armed && !reversing && at_zero;
        if (fire) lvl_nx = arm_up ? lvl + 2'd1 : lvl - 2'd1;
        else      lvl_nx = lvl;
        cont      = fire && (arm_up ? (lvl_nx != 2'd3) : (lvl_nx != 2'd0));
        load      = start || cont;
        use_up    = start ? en_s : arm_up;
    end

    // Pick the delay of the flag that moves next.
    always_comb begin
        load_val = '0;
        if (use_up) begin
            case (lvl_nx)
                2'd0:    load_val = up_dly[0];
                2'd1:    load_val = up_dly[1];
                2'd2:    load_val = up_dly[2];
                default: load_val = '0;
            endcase
        end else begin
            case (lvl_nx)
                2'd1:    load_val = dn_dly[0];
                2'd2:    load_val = dn_dly[1];
                2'd3:    load_val = dn_dly[2];
                default: load_val = '0;
            endcase
        end
    end

    // Register the level and the armed step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl    <= 2'd0;
            armed  <= 1'b0;
            arm_up <= 1'b0;
        end else begin
            lvl <= lvl_nx;
            if (load) begin
                armed  <= 1'b1;
                arm_up <= use_up;
            end else if (fire || reversing) begin
                armed  <= 1'b0;
            end
        end
    end

    // Report the phase from the level and the armed direction.
    always_comb begin
        if (armed)             status = arm_up ? ST_RAMP_UP : ST_RAMP_DOWN;
        else if (lvl == 2'd0)  status = ST_IDLE_LOW;
        else if (lvl == 2'd3)  status = ST_ALL_HIGH;
        else                   status = en_s ? ST_RAMP_UP : ST_RAMP_DOWN;
    end
endmodule

// File: rtl/rail_sequencer.sv
// Module: rail_sequencer (top)
// Three-flag power sequencer. It synchronises the enable, runs the shared
// step timer and drives thermometer-coded release flags. Assumes the
// delay ports are static while a sequence runs.
module rail_sequencer #(
    parameter int CNT_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_async,
    input  logic [CNT_W-1:0] up_dly_f1,
    input  logic [CNT_W-1:0] up_dly_f2,
    input  logic [CNT_W-1:0] up_dly_f3,
    input  logic [CNT_W-1:0] dn_dly_f1,
    input  logic [CNT_W-1:0] dn_dly_f2,
    input  logic [CNT_W-1:0] dn_dly_f3,
    output logic [2:0]       flags,
    output logic [1:0]       status
);
    import seq_pkg::*;

    logic                  en_s;
    logic                  at_zero, load;
    logic [CNT_W-1:0]      load_val;
    logic [1:0]            lvl;
    logic [2:0][CNT_W-1:0] up_dly, dn_dly;
    seq_status_e           st;

    assign up_dly = {up_dly_f3, up_dly_f2, up_dly_f1};
    assign dn_dly = {dn_dly_f3, dn_dly_f2, dn_dly_f1};

    en_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(en_async), .q_sync(en_s)
    );

    step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .at_zero(at_zero)
    );

    seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en_s(en_s), .at_zero(at_zero),
        .up_dly(up_dly), .dn_dly(dn_dly), .load(load), .load_val(load_val),
        .lvl(lvl), .status(st)
    );

    // Flag g is asserted while the level exceeds g.
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        assign flags[g] = (lvl > 2'(g));
    end

    assign status = st;
endmodule

// File: rtl/rail_sequencer_chk.sv
// Module: rail_sequencer_chk
// Property checker bound to rail_sequencer. It watches the flags, the
// status and the synchronised enable.
module rail_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_s,
    input logic [2:0] flags,
    input logic [1:0] status
);
    AST_THERMO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 3'b000 || flags == 3'b001 || flags == 3'b011 || flags == 3'b111)); // R2
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(flags ^ $past(flags)) <= 1)); // R2
    AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags)) != 3'b000) |-> $past(en_s)); // R3
    AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((~flags & $past(flags)) != 3'b000) |-> !$past(en_s)); // R5
    AST_IDLE_MEANS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd0) |-> (flags == 3'b000)); // R9
    AST_HIGH_MEANS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd2) |-> (flags == 3'b111)); // R9
endmodule

bind rail_sequencer rail_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .flags(flags), .status(status)
);

// File: tb/sim_rail_sequencer.sv
module sim_rail_sequencer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] u1 = '0, u2 = '0, u3 = '0, d1 = '0, d2 = '0, d3 = '0;
    logic [2:0]   flags;
    logic [1:0]   status;
    int           n_run = 0, n_fail = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    rail_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .en_async(en),
        .up_dly_f1(u1), .up_dly_f2(u2), .up_dly_f3(u3),
        .dn_dly_f1(d1), .dn_dly_f2(d2), .dn_dly_f3(d3),
        .flags(flags), .status(status)
    );

    function automatic int first_lat(input int d); return d + 4; endfunction
    function automatic int gap(input int d);       return d + 1; endfunction
    function automatic logic [1:0] exp_status(input logic [2:0] f, input bit up);
        if (f == 3'b000) return 2'd0;
        if (f == 3'b111) return 2'd2;
        return up ? 2'd1 : 2'd3;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for the next flag change; check its value, its cycle and the status.
    task automatic expect_step(input logic [2:0] ef, input int ecyc, input bit up,
                               input string req);
        logic [2:0] prev = flags;
        int c = 0;
        while (c < ecyc + 60) begin
            @(negedge clk);
            c++;
            if (flags != prev) break;
        end
        check(flags == ef, {req, " flags"}, flags, ef);
        check(c == ecyc, {req, " cycle"}, c, ecyc);
        check(status == exp_status(flags, up), "R9 status", status, exp_status(flags, up));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(flags == 3'b000, "R1 flags in reset", flags, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(flags == 3'b000, "R1 flags after reset", flags, 0);
        check(status == 2'd0, "R1 status idle", status, 0);

        // R3 R4 R5: random delay sets, full rise and fall.
        for (int i = 0; i < 6; i++) begin
            u1 = W'($urandom_range(7, 0)); u2 = W'($urandom_range(7, 0));
            u3 = W'($urandom_range(7, 0)); d1 = W'($urandom_range(7, 0));
            d2 = W'($urandom_range(7, 0)); d3 = W'($urandom_range(7, 0));
            en = 1'b1;
            expect_step(3'b001, first_lat(int'(u1)), 1'b1, "R3");
            expect_step(3'b011, gap(int'(u2)), 1'b1, "R4");
            expect_step(3'b111, gap(int'(u3)), 1'b1, "R4");
            repeat (5) @(negedge clk);
            check(status == 2'd2, "R9 all-high hold", status, 2);
            en = 1'b0;
            expect_step(3'b011, first_lat(int'(d3)), 1'b0, "R5");
            expect_step(3'b001, gap(int'(d2)), 1'b0, "R5");
            expect_step(3'b000, gap(int'(d1)), 1'b0, "R5");
            repeat (5) @(negedge clk);
        end

        // R6: all delays zero.
        {u1, u2, u3, d1, d2, d3} = '0;
        en = 1'b1;
        expect_step(3'b001, 4, 1'b1, "R6");
        expect_step(3'b011, 1, 1'b1, "R6");
        expect_step(3'b111, 1, 1'b1, "R6");
        en = 1'b0;
        expect_step(3'b011, 4, 1'b0, "R6");
        expect_step(3'b001, 1, 1'b0, "R6");
        expect_step(3'b000, 1, 1'b0, "R6");
        repeat (5) @(negedge clk);

        // R7: drop enable after flag 1 rose; flag 2 must never rise.
        u1 = 16'd2; u2 = 16'd30; u3 = 16'd3; d1 = 16'd5; d2 = 16'd9; d3 = 16'd9;
        en = 1'b1;
        expect_step(3'b001, first_lat(2), 1'b1, "R7 setup");
        en = 1'b0;
        expect_step(3'b000, first_lat(5), 1'b0, "R7");
        repeat (40) @(negedge clk);
        check(flags == 3'b000, "R7 no later rise", flags, 0);
        check(status == 2'd0, "R7 status idle", status, 0);

        // R8: raise enable after flag 3 fell; flag 2 must never fall.
        u1 = 16'd1; u2 = 16'd1; u3 = 16'd6; d1 = 16'd2; d2 = 16'd30; d3 = 16'd0;
        en = 1'b1;
        expect_step(3'b001, first_lat(1), 1'b1, "R8 setup");
        expect_step(3'b011, gap(1), 1'b1, "R8 setup");
        expect_step(3'b111, gap(6), 1'b1, "R8 setup");
        en = 1'b0;
        expect_step(3'b011, first_lat(0), 1'b0, "R8 setup");
        en = 1'b1;
        expect_step(3'b111, first_lat(6), 1'b1, "R8");
        repeat (40) @(negedge clk);
        check(flags == 3'b111, "R8 held high", flags, 7);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule